// File: doc/BRIEF.md
# Asynchronous DRAM Refresh Sequencer

This block keeps every row of an asynchronous DRAM alive. It sits between a host memory port and the row/column strobes. A free-running interval timer adds one refresh to an owed count every `INTERVAL` clocks. Whenever the strobes are free, the sequencer pays these debts one cycle at a time. It never interrupts a host access that is already granted. While any refresh is owed, it also keeps the next host request waiting. Each refresh cycle uses one of two styles, chosen by a mode input. In the first style, the column strobe leads the row strobe and the memory supplies the row itself. In the second style, the row strobe pulses alone and the block presents the row from its own wrapping counter.

The block can also park the memory in self-refresh on request. It does this with a column-first entry cycle and then holds the row strobe low for a minimum time. On leaving, it drives both strobes high for a minimum recovery time. If the burst policy input is set at that moment, the block refreshes the whole array back to back before the host may return. All timings are clock counts given as parameters. Each count is the nanosecond minimum divided by the clock period and rounded up.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it, `ras_n` and `cas_n` are 1 and `host_gnt`, `ref_busy`, `sr_active` and `row_addr` are 0.
- R2: Outside self-refresh and outside a catch-up burst, the timer adds one owed refresh every `INTERVAL` clocks. The owed count saturates at `MAX_OWED`, so further ticks are lost. Each refresh cycle that is started removes one from the owed count.
- R3: `host_gnt` rises only from idle when nothing is owed. It stays high while `host_req` stays high, and no strobe goes low while it is high. It drops in the cycle after `host_req` falls.
- R4: When `mode_ras_only` is 0, a refresh lowers `cas_n` for `T_CSR` cycles with `ras_n` high. Both strobes are then low for `T_RAS` cycles, and then both rise together. `row_addr` is 0 throughout.
- R5: When `mode_ras_only` is 1, a refresh keeps `cas_n` at 1 and lowers `ras_n` for `T_RAS` cycles, with `row_addr` set to the internal row counter. The counter then advances by one, modulo 2^`ROW_BITS`.
- R6: After every refresh cycle, both strobes stay high for `T_RP` cycles plus one idle cycle before anything else starts.
- R7: In idle, an owed refresh (or burst refresh) wins over a self-refresh entry request. A self-refresh entry request wins over a host request.
- R8: Self-refresh entry always uses column-first order, whatever the mode: `cas_n` is low for `T_CSR` cycles, and then both strobes are low. `ras_n` stays low for at least `T_RASS` cycles and until `sr_exit` is seen. `sr_active` is 1 exactly while that hold lasts.
- R9: On exit, both strobes are high for `T_RPS` cycles. The owed count and the timer are cleared for the whole of self-refresh.
- R10: If `burst_policy` is 1 when the exit recovery ends, exactly 2^`ROW_BITS` refresh cycles run before any grant. If it is 0, none are added.
- R11: In row-strobe-only mode, outside self-refresh, no row goes longer than (2^`ROW_BITS`+2)·`INTERVAL` clocks without a refresh, provided host accesses are short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ras_only | input | 1 | 1: row-strobe-only refresh, 0: column-first refresh |
| burst_policy | input | 1 | 1: full-array burst after self-refresh exit |
| sr_enter | input | 1 | Level request to enter self-refresh |
| sr_exit | input | 1 | Level request to leave self-refresh |
| host_req | input | 1 | Host wants the memory; held for the whole access |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_BITS | Row driven during row-strobe-only refresh, else 0 |
| host_gnt | output | 1 | Host owns the memory |
| ref_busy | output | 1 | Sequencer owns the strobes (refresh or self-refresh) |
| sr_active | output | 1 | Memory is held in self-refresh |

## Verification
Two events can land on the same clock: a timer tick, and the start of a refresh that consumes an owed entry. When both occur, the owed count must net to no change. A host request can also arrive in the very cycle the owed count first becomes nonzero, and there the refresh must win. The bench provokes both by raising short host requests at an offset that shifts every burst. Over the run, the request edges sweep every phase of the refresh interval. A behavioural model predicts each strobe, the grant and the row on every clock, and any difference is reported against the requirement of the phase the model is in.

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq #(
  parameter int ROW_BITS = 10,
  parameter int INTERVAL = 1560,
  parameter int T_CSR    = 1,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int T_RASS   = 10000,
  parameter int T_RPS    = 11,
  parameter int MAX_OWED = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_ras_only,
  input  logic                burst_policy,
  input  logic                sr_enter,
  input  logic                sr_exit,
  input  logic                host_req,
  output logic                ras_n,
  output logic                cas_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                host_gnt,
  output logic                ref_busy,
  output logic                sr_active
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int TW   = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int OW   = $clog2(MAX_OWED + 1);
  localparam int M1   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int M2   = (T_RP > T_RPS) ? T_RP : T_RPS;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int CMAX = (M3 > T_RASS) ? M3 : T_RASS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int LATE_LIMIT = (ROWS + 2) * INTERVAL;
  localparam int AW   = $clog2(LATE_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HOST, S_CBR_LEAD, S_CBR_RAS, S_RO_RAS,
    S_PRE, S_SR_LEAD, S_SR_HOLD, S_SR_EXIT
  } st_t;

  st_t                 state;
  logic [CW-1:0]       cnt;
  logic [TW-1:0]       timer;
  logic [OW-1:0]       owed, owed_nx;
  logic [OW:0]         owed_sum;
  logic [ROW_BITS:0]   burst_left;
  logic [ROW_BITS-1:0] row;
  logic                in_sr, timer_run, tick, need, start, go_sr, dec, cnt_done;

  assign in_sr     = (state == S_SR_LEAD) || (state == S_SR_HOLD) || (state == S_SR_EXIT);
  assign timer_run = !in_sr && (burst_left == '0);
  assign tick      = timer_run && (timer == TW'(INTERVAL - 1));
  assign need      = (burst_left != '0) || (owed != '0);
  assign start     = (state == S_IDLE) && need;
  assign go_sr     = (state == S_IDLE) && !need && sr_enter;
  assign dec       = start && (burst_left == '0);
  assign cnt_done  = (cnt == '0);

  assign owed_sum = {1'b0, owed} + {{OW{1'b0}}, tick} - {{OW{1'b0}}, dec};
  assign owed_nx  = (owed_sum > (OW+1)'(MAX_OWED)) ? OW'(MAX_OWED) : owed_sum[OW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                timer <= '0;
    else if (!timer_run || tick) timer <= '0;
    else                       timer <= timer + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              owed <= '0;
    else if (in_sr || go_sr) owed <= '0;
    else                     owed <= owed_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      burst_left <= '0;
    else if (state == S_SR_EXIT && cnt_done)
      burst_left <= burst_policy ? (ROW_BITS+1)'(ROWS) : '0;
    else if (start && burst_left != '0)
      burst_left <= burst_left - (ROW_BITS+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          row <= '0;
    else if (state == S_RO_RAS && cnt_done) row <= row + ROW_BITS'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (need) begin
            state <= mode_ras_only ? S_RO_RAS : S_CBR_LEAD;
            cnt   <= mode_ras_only ? CW'(T_RAS - 1) : CW'(T_CSR - 1);
          end else if (sr_enter) begin
            state <= S_SR_LEAD;
            cnt   <= CW'(T_CSR - 1);
          end else if (host_req) begin
            state <= S_HOST;
          end
        end
        S_HOST: if (!host_req) state <= S_IDLE;
        S_CBR_LEAD: begin
          if (cnt_done) begin state <= S_CBR_RAS; cnt <= CW'(T_RAS - 1); end
          else cnt <= cnt - CW'(1);
        end
        S_CBR_RAS, S_RO_RAS: begin
          if (cnt_done) begin state <= S_PRE; cnt <= CW'(T_RP - 1); end
          else cnt <= cnt - CW'(1);
        end
        S_PRE: begin
          if (cnt_done) state <= S_IDLE;
          else cnt <= cnt - CW'(1);
        end
        S_SR_LEAD: begin
          if (cnt_done) begin state <= S_SR_HOLD; cnt <= CW'(T_RASS - 1); end
          else cnt <= cnt - CW'(1);
        end
        S_SR_HOLD: begin
          if (!cnt_done) cnt <= cnt - CW'(1);
          else if (sr_exit) begin state <= S_SR_EXIT; cnt <= CW'(T_RPS - 1); end
        end
        S_SR_EXIT: begin
          if (cnt_done) state <= S_IDLE;
          else cnt <= cnt - CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ras_n     = !((state == S_CBR_RAS) || (state == S_RO_RAS) || (state == S_SR_HOLD));
  assign cas_n     = !((state == S_CBR_LEAD) || (state == S_CBR_RAS) ||
                       (state == S_SR_LEAD) || (state == S_SR_HOLD));
  assign row_addr  = (state == S_RO_RAS) ? row : '0;
  assign host_gnt  = (state == S_HOST);
  assign ref_busy  = (state != S_IDLE) && (state != S_HOST);
  assign sr_active = (state == S_SR_HOLD);

  logic [AW-1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n || !mode_ras_only || in_sr)                      age <= '0;
    else if (state == S_RO_RAS && cnt_done && row == ROW_BITS'(ROWS - 1)) age <= '0;
    else if (age != AW'(LATE_LIMIT))                            age <= age + AW'(1);
  end

  a_r3_gnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (ras_n && cas_n));
  a_r3_gnt_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && ref_busy));
  a_r7_gnt_only_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(!need));
  a_r2_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));
  a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
  a_r5_ro_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n) |=> (cas_n || ras_n));
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  a_r8_sr_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (!ras_n && !cas_n));
  a_r11_row_age: assert property (@(posedge clk) disable iff (!rst_n)
    age < AW'(LATE_LIMIT));
endmodule

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
  localparam int RB = 4, IV = 20, TCS = 2, TRA = 4, TRP = 3, TRS = 12, TRX = 5, MO = 3;
  localparam int ROWS = 1 << RB;
  localparam int LIMIT = (ROWS + 2) * IV;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, bpol = 1'b0, sren = 1'b0, srex = 1'b0, hreq = 1'b0;
  logic ras_n, cas_n, host_gnt, ref_busy, sr_active;
  logic [RB-1:0] row_addr;

  dram_refresh_seq #(.ROW_BITS(RB), .INTERVAL(IV), .T_CSR(TCS), .T_RAS(TRA), .T_RP(TRP),
                     .T_RASS(TRS), .T_RPS(TRX), .MAX_OWED(MO)) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode), .burst_policy(bpol),
    .sr_enter(sren), .sr_exit(srex), .host_req(hreq),
    .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr), .host_gnt(host_gnt),
    .ref_busy(ref_busy), .sr_active(sr_active));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // phases: 0 idle 1 host 2 cbr lead 3 cbr ras 4 ro ras 5 precharge 6 sr lead 7 sr hold 8 sr exit
  int m_ph = 0, m_el = 0, m_owed = 0, m_burst = 0, m_row = 0, m_tmr = 0;
  int n_ph, n_owed, n_burst, n_row;
  bit run, tk, strt, tosr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_owed = 0; m_burst = 0; m_row = 0; m_tmr = 0;
    end else begin
      run = !(m_ph >= 6) && m_burst == 0;
      tk = run && m_tmr == IV - 1;
      n_ph = m_ph; n_owed = m_owed; n_burst = m_burst; n_row = m_row;
      strt = 0; tosr = 0;
      case (m_ph)
        0: if (m_burst > 0 || m_owed > 0) begin strt = 1; n_ph = mode ? 4 : 2; end
           else if (sren) begin tosr = 1; n_ph = 6; end
           else if (hreq) n_ph = 1;
        1: if (!hreq) n_ph = 0;
        2: if (m_el + 1 >= TCS) n_ph = 3;
        3: if (m_el + 1 >= TRA) n_ph = 5;
        4: if (m_el + 1 >= TRA) begin n_ph = 5; n_row = (m_row + 1) % ROWS; end
        5: if (m_el + 1 >= TRP) n_ph = 0;
        6: if (m_el + 1 >= TCS) n_ph = 7;
        7: if (m_el + 1 >= TRS && srex) n_ph = 8;
        8: if (m_el + 1 >= TRX) begin n_ph = 0; n_burst = bpol ? ROWS : 0; end
        default: n_ph = 0;
      endcase
      if (m_ph >= 6 || tosr) n_owed = 0;
      else begin
        if (strt && m_burst == 0) n_owed = n_owed - 1;
        if (tk) n_owed = (n_owed + 1 > MO) ? MO : n_owed + 1;
      end
      if (strt && m_burst > 0) n_burst = m_burst - 1;
      m_tmr = run ? (tk ? 0 : m_tmr + 1) : 0;
      m_el = (n_ph != m_ph) ? 0 : m_el + 1;
      m_ph = n_ph; m_owed = n_owed; m_burst = n_burst; m_row = n_row;
    end
  end

  function automatic string tag_for(input int ph, input int burst);
    if (burst > 0) return "R10";
    case (ph)
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R6";
      6, 7: return "R8";
      8: return "R9";
      default: return "R2";
    endcase
  endfunction

  int cyc = 0, n_fall = 0, high_run = 100, low_run = 0, cas_run = 0;
  int last_high_run = 0, last_low_run = 0, ro_last = 0;
  bit prev_ras = 1'b1, ro_valid = 1'b0, age_on = 1'b0;
  int seen [ROWS];
  int act_v, exp_v;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    act_v = int'({ras_n, cas_n, host_gnt, ref_busy, sr_active, row_addr});
    exp_v = int'({!(m_ph == 3 || m_ph == 4 || m_ph == 7),
                  !(m_ph == 2 || m_ph == 3 || m_ph == 6 || m_ph == 7),
                  m_ph == 1, m_ph >= 2, m_ph == 7,
                  (m_ph == 4) ? RB'(m_row) : RB'(0)});
    chk(act_v == exp_v, tag_for(m_ph, m_burst), act_v, exp_v);
    if (prev_ras && !ras_n) begin
      n_fall++;
      last_high_run = high_run;
      chk(high_run >= TRP, "R6 precharge run", high_run, TRP);
      if (!cas_n) chk(cas_run >= TCS, "R4 cas lead", cas_run, TCS);
      else begin
        if (ro_valid) chk(int'(row_addr) == (ro_last + 1) % ROWS, "R5 row step",
                          int'(row_addr), (ro_last + 1) % ROWS);
        ro_last = int'(row_addr); ro_valid = 1'b1;
        if (age_on) chk(cyc - seen[row_addr] <= LIMIT, "R11 row age", cyc - seen[row_addr], LIMIT);
        seen[row_addr] = cyc;
      end
    end
    if (!prev_ras && ras_n) last_low_run = low_run;
    high_run = ras_n ? high_run + 1 : 0;
    low_run  = ras_n ? 0 : low_run + 1;
    cas_run  = cas_n ? 0 : cas_run + 1;
    prev_ras = ras_n;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  bit done = 1'b0;
  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  int snap, guard, fall0;
  bit r9_done;
  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes", int'({ras_n, cas_n}), 3);
    chk(!host_gnt && !ref_busy && !sr_active, "R1 flags",
        int'({host_gnt, ref_busy, sr_active}), 0);
    chk(row_addr == '0, "R1 row", int'(row_addr), 0);
    #1 rst_n = 1'b1;
    step();
    chk(ras_n && cas_n && !host_gnt && !ref_busy, "R1 first cycle",
        int'({ras_n, cas_n, host_gnt, ref_busy}), 12);

    // column-first refresh against short host requests at shifting offsets
    for (int k = 0; k < 30; k++) begin
      repeat (k % 7 + 6) step();
      hreq = 1'b1;
      repeat (4) step();
      hreq = 1'b0;
    end

    // long host hold: owed count saturates, no refresh while granted
    repeat (20) step();
    hreq = 1'b1;
    repeat (10) step();
    fall0 = n_fall;
    repeat (140) step();
    chk(n_fall == fall0, "R3 no refresh under grant", n_fall - fall0, 0);
    hreq = 1'b0;
    repeat (80) step();

    // self-refresh without burst; entry contends with a host request
    sren = 1'b1; hreq = 1'b1;
    guard = 0;
    while (!sr_active && guard < 200) begin
      chk(!host_gnt, "R7 entry beats host", int'(host_gnt), 0);
      step(); guard++;
    end
    sren = 1'b0;
    repeat (30) step();
    srex = 1'b1;
    guard = 0;
    while (sr_active && guard < 200) begin step(); guard++; end
    srex = 1'b0;
    chk(last_low_run >= TRS, "R8 hold length", last_low_run, TRS);
    snap = n_fall; guard = 0;
    while (!host_gnt && guard < 200) begin step(); guard++; end
    chk(n_fall == snap, "R10 no burst when distributed", n_fall - snap, 0);
    hreq = 1'b0;
    repeat (10) step();

    // self-refresh with burst policy, row-strobe-only mode
    bpol = 1'b1; mode = 1'b1;
    repeat (5) step();
    sren = 1'b1;
    guard = 0;
    while (!sr_active && guard < 200) begin step(); guard++; end
    sren = 1'b0;
    repeat (15) step();
    hreq = 1'b1; srex = 1'b1;
    guard = 0;
    while (sr_active && guard < 200) begin step(); guard++; end
    srex = 1'b0;
    snap = n_fall; guard = 0; r9_done = 1'b0;
    while (!host_gnt && guard < 600) begin
      step(); guard++;
      if (!r9_done && n_fall == snap + 1) begin
        chk(last_high_run >= TRX, "R9 exit recovery", last_high_run, TRX);
        r9_done = 1'b1;
      end
    end
    chk(n_fall - snap == ROWS, "R10 full burst", n_fall - snap, ROWS);
    hreq = 1'b0;
    bpol = 1'b0;

    // steady row-strobe-only refresh with short host accesses
    for (int r = 0; r < ROWS; r++) seen[r] = cyc;
    age_on = 1'b1;
    for (int k = 0; k < 60; k++) begin
      repeat (k % 5 + 8) step();
      hreq = 1'b1;
      repeat (3) step();
      hreq = 1'b0;
    end
    for (int r = 0; r < ROWS; r++)
      chk(cyc - seen[r] <= LIMIT, "R11 every row recent", cyc - seen[r], LIMIT);
    repeat (5) step();
    summary();
  end
endmodule